// File: doc/BRIEF.md
# Aliased Single/Double Floating-Point Register Bank

This block holds the floating-point operand storage of a processor core. It can be viewed at two sizes over one store: 32 single-precision 32-bit registers, or 16 double-precision 64-bit registers. Each double register is made of two adjacent single registers. The even single register is the low half and the odd single register is the high half. For example, single 12 is bits 31:0 of double 6 and single 13 is bits 63:32 of double 6.

The bank has two combinational read ports and one synchronous write port. Every port carries its own size select and a 5-bit index. A single write replaces one 32-bit word. A double write replaces both words of a pair on the same clock edge. A double access whose index lies beyond the last pair is illegal. For a write, this is reported at once and the write is dropped. For a read, the port returns zero.

Top module: `fprf_bank`

## Requirements
- R1: While rst_ni is low, and after it rises, every register reads as zero at both sizes on both read ports.
- R2: A single read (size select 0) of index i returns word i on bits 31:0 and zero on bits 63:32.
- R3: A double read (size select 1) of index n below 16 returns word 2n+1 on bits 63:32 and word 2n on bits 31:0. Single 12 and 13 are therefore the low and high halves of double 6.
- R4: A single write of index i stores wr_data_i[31:0] into word i only. The partner word i^1 and all other words keep their values.
- R5: A double write of index n below 16 stores wr_data_i[31:0] into word 2n and wr_data_i[63:32] into word 2n+1 on the same clock edge.
- R6: A read in the cycle after a write returns the written value, whatever size the write used and whatever size the read uses.
- R7: A read that addresses storage being written in the same cycle returns the value held before that write.
- R8: A double write with an index of 16 or more raises wr_illegal_o in the same cycle and leaves every word unchanged.
- R9: A double read with an index of 16 or more returns zero.
- R10: The two read ports are independent. Each returns its own address at its own size in the same cycle.
- R11: wr_illegal_o is low whenever wr_en_i is low or the write is single-size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all words |
| wr_en_i | input | 1 | Write request |
| wr_dbl_i | input | 1 | Write size: 0 single, 1 double |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | 64 | Write data; single writes use bits 31:0 |
| wr_illegal_o | output | 1 | Double write index out of range; write dropped |
| ra_dbl_i | input | 1 | Read port A size |
| ra_idx_i | input | 5 | Read port A index |
| ra_data_o | output | 64 | Read port A data |
| rb_dbl_i | input | 1 | Read port B size |
| rb_idx_i | input | 5 | Read port B index |
| rb_data_o | output | 64 | Read port B data |

## Verification
If one stored word is wrong, the fault shows up the first time that word is read at either size. A corrupted partner half after a single write shows up as a wrong upper or lower half when the pair is read as a double. The bench reads on every cycle, so a fault that a write has exposed appears one cycle after the write edge. An error in aliasing or in the same-cycle read timing is visible on the same cycle as the stimulus, because the read path holds no register.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned FP_WORD_W     = 32;
  localparam int unsigned FP_NUM_SINGLE = 32;

  typedef enum logic {
    SZ_SINGLE = 1'b0,
    SZ_DOUBLE = 1'b1
  } fp_size_e;
endpackage

// File: rtl/fprf_wr_dec.sv
module fprf_wr_dec #(
  parameter int unsigned WORD_W     = fprf_pkg::FP_WORD_W,
  parameter int unsigned NUM_SINGLE = fprf_pkg::FP_NUM_SINGLE,
  localparam int unsigned IDX_W     = $clog2(NUM_SINGLE),
  localparam int unsigned PAIRS     = NUM_SINGLE / 2
) (
  input  logic                                 wr_en_i,
  input  logic                                 wr_dbl_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  logic [2*WORD_W-1:0]                  wr_data_i,
  output logic [NUM_SINGLE-1:0]                we_o,
  output logic [NUM_SINGLE-1:0][WORD_W-1:0]    wd_o,
  output logic                                 illegal_o
);
  import fprf_pkg::*;

  fp_size_e size;
  assign size      = fp_size_e'(wr_dbl_i);
  assign illegal_o = wr_en_i && (size == SZ_DOUBLE) && (int'(wr_idx_i) >= int'(PAIRS));

  for (genvar w = 0; w < int'(NUM_SINGLE); w++) begin : g_word
    localparam logic [IDX_W-1:0] SIDX = IDX_W'(w);
    localparam logic [IDX_W-1:0] PIDX = IDX_W'(w / 2);
    localparam int unsigned      HALF = w % 2;
    // a matching pair index is always in range, so illegal writes hit no word
    assign we_o[w] = wr_en_i && ((size == SZ_DOUBLE) ? (wr_idx_i == PIDX)
                                                     : (wr_idx_i == SIDX));
    assign wd_o[w] = (size == SZ_DOUBLE) ? wr_data_i[HALF*WORD_W +: WORD_W]
                                         : wr_data_i[WORD_W-1:0];
  end
endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int unsigned WORD_W     = fprf_pkg::FP_WORD_W,
  parameter int unsigned NUM_SINGLE = fprf_pkg::FP_NUM_SINGLE
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_SINGLE-1:0]             we_i,
  input  logic [NUM_SINGLE-1:0][WORD_W-1:0] wd_i,
  output logic [NUM_SINGLE-1:0][WORD_W-1:0] mem_o
);
  for (genvar w = 0; w < int'(NUM_SINGLE); w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (we_i[w]) word_q <= wd_i[w];
    end
    assign mem_o[w] = word_q;
  end
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port #(
  parameter int unsigned WORD_W     = fprf_pkg::FP_WORD_W,
  parameter int unsigned NUM_SINGLE = fprf_pkg::FP_NUM_SINGLE,
  localparam int unsigned IDX_W     = $clog2(NUM_SINGLE),
  localparam int unsigned PAIRS     = NUM_SINGLE / 2
) (
  input  logic [NUM_SINGLE-1:0][WORD_W-1:0] mem_i,
  input  logic                              dbl_i,
  input  logic [IDX_W-1:0]                  idx_i,
  output logic [2*WORD_W-1:0]               data_o
);
  import fprf_pkg::*;

  logic [IDX_W-1:0] lo_idx, hi_idx;
  assign lo_idx = {idx_i[IDX_W-2:0], 1'b0};
  assign hi_idx = {idx_i[IDX_W-2:0], 1'b1};

  always_comb begin
    if (fp_size_e'(dbl_i) == SZ_SINGLE)
      data_o = {{WORD_W{1'b0}}, mem_i[idx_i]};
    else if (int'(idx_i) < int'(PAIRS))
      data_o = {mem_i[hi_idx], mem_i[lo_idx]};
    else
      data_o = '0;
  end
endmodule

// File: rtl/fprf_bank.sv
module fprf_bank #(
  parameter int unsigned WORD_W     = fprf_pkg::FP_WORD_W,
  parameter int unsigned NUM_SINGLE = fprf_pkg::FP_NUM_SINGLE,
  localparam int unsigned IDX_W     = $clog2(NUM_SINGLE),
  localparam int unsigned PAIRS     = NUM_SINGLE / 2,
  localparam int unsigned N_RD      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  wr_dbl_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [2*WORD_W-1:0]   wr_data_i,
  output logic                  wr_illegal_o,
  input  logic                  ra_dbl_i,
  input  logic [IDX_W-1:0]      ra_idx_i,
  output logic [2*WORD_W-1:0]   ra_data_o,
  input  logic                  rb_dbl_i,
  input  logic [IDX_W-1:0]      rb_idx_i,
  output logic [2*WORD_W-1:0]   rb_data_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [NUM_SINGLE-1:0]             we;
  logic [NUM_SINGLE-1:0][WORD_W-1:0] wd;
  logic [NUM_SINGLE-1:0][WORD_W-1:0] mem;

  fprf_wr_dec #(.WORD_W(WORD_W), .NUM_SINGLE(NUM_SINGLE)) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_dbl_i (wr_dbl_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .we_o     (we),
    .wd_o     (wd),
    .illegal_o(wr_illegal_o)
  );

  fprf_store #(.WORD_W(WORD_W), .NUM_SINGLE(NUM_SINGLE)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we),
    .wd_i  (wd),
    .mem_o (mem)
  );

  logic [N_RD-1:0]                  rd_dbl;
  logic [N_RD-1:0][IDX_W-1:0]       rd_idx;
  logic [N_RD-1:0][2*WORD_W-1:0]    rd_data;

  assign rd_dbl    = {rb_dbl_i, ra_dbl_i};
  assign rd_idx    = {rb_idx_i, ra_idx_i};
  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];

  for (genvar p = 0; p < int'(N_RD); p++) begin : g_rd
    fprf_rd_port #(.WORD_W(WORD_W), .NUM_SINGLE(NUM_SINGLE)) u_rd (
      .mem_i (mem),
      .dbl_i (rd_dbl[p]),
      .idx_i (rd_idx[p]),
      .data_o(rd_data[p])
    );
  end

  // single write lands in its word
  p_single_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_dbl_i |=> mem[$past(wr_idx_i)] == $past(wr_data_i[WORD_W-1:0]));

  // partner half untouched by a single write
  p_partner_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_dbl_i |=> mem[$past(wr_idx_i) ^ ONE] == $past(mem[wr_idx_i ^ ONE]));

  // double write fills both halves on one edge
  p_double_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_dbl_i && !wr_illegal_o |=>
      {mem[{$past(wr_idx_i[IDX_W-2:0]), 1'b1}], mem[{$past(wr_idx_i[IDX_W-2:0]), 1'b0}]}
        == $past(wr_data_i));

  p_illegal_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |=> $stable(mem));

  p_illegal_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || !wr_dbl_i) |-> !wr_illegal_o);

  // port A single view equals matching half of port B double view
  p_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_dbl_i && rb_dbl_i && (rb_idx_i == (ra_idx_i >> 1)) |->
      ra_data_o[WORD_W-1:0] == (ra_idx_i[0] ? rb_data_o[2*WORD_W-1:WORD_W]
                                            : rb_data_o[WORD_W-1:0]));

  p_oob_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_dbl_i && (int'(ra_idx_i) >= int'(PAIRS)) |-> ra_data_o == '0);
endmodule

// File: tb/tb_fprf_bank.sv
`timescale 1ns/1ps
module tb_fprf_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_dbl_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        wr_illegal_o;
  logic        ra_dbl_i = 1'b0, rb_dbl_i = 1'b0;
  logic [4:0]  ra_idx_i = '0, rb_idx_i = '0;
  logic [63:0] ra_data_o, rb_data_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [32];

  always #10 clk_i = ~clk_i;

  fprf_bank dut (.*);

  function automatic logic [63:0] mread(logic dbl, logic [4:0] idx);
    if (!dbl) return {32'h0, mdl[idx]};
    if (idx >= 16) return 64'h0;
    return {mdl[2*idx+1], mdl[2*idx]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, check outputs against model (pre-edge), then commit write
  task automatic step(string tag, logic we, logic wdb, logic [4:0] wi, logic [63:0] wdat,
                      logic ad, logic [4:0] ai, logic bd, logic [4:0] bi);
    @(negedge clk_i);
    wr_en_i = we; wr_dbl_i = wdb; wr_idx_i = wi; wr_data_i = wdat;
    ra_dbl_i = ad; ra_idx_i = ai; rb_dbl_i = bd; rb_idx_i = bi;
    #1;
    chk({tag, " port A"}, ra_data_o, mread(ad, ai));
    chk({tag, " port B"}, rb_data_o, mread(bd, bi));
    chk({tag, " illegal flag"}, {63'h0, wr_illegal_o}, {63'h0, we && wdb && (wi >= 16)});
    @(posedge clk_i);
    if (we) begin
      if (!wdb) mdl[wi] = wdat[31:0];
      else if (wi < 16) begin
        mdl[2*wi]   = wdat[31:0];
        mdl[2*wi+1] = wdat[63:32];
      end
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    // R1: outputs during reset
    repeat (2) @(negedge clk_i);
    ra_dbl_i = 1'b1; ra_idx_i = 5'd3; rb_dbl_i = 1'b0; rb_idx_i = 5'd31;
    #1;
    chk("R1 reset A", ra_data_o, 64'h0);
    chk("R1 reset B", rb_data_o, 64'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    step("R1", 0, 0, 0, 0, 1, 5'd15, 0, 5'd0);

    // R2/R3: S12 and S13 as halves of D6
    step("R2", 1, 0, 5'd12, 64'hdead_0000_1111_2222, 0, 5'd12, 0, 5'd13);
    step("R6", 1, 0, 5'd13, 64'h0000_0000_3333_4444, 0, 5'd12, 1, 5'd6);
    step("R3", 0, 0, 0, 0, 1, 5'd6, 0, 5'd13);
    // R4: single write keeps partner
    step("R4", 1, 0, 5'd12, 64'h0_5555_6666, 0, 5'd13, 1, 5'd6);
    step("R4", 0, 0, 0, 0, 1, 5'd6, 0, 5'd13);
    // R5/R6: double write seen as singles next cycle
    step("R5", 1, 1, 5'd3, 64'haaaa_bbbb_cccc_dddd, 0, 5'd6, 0, 5'd7);
    step("R5", 0, 0, 0, 0, 0, 5'd6, 0, 5'd7);
    // R7: same-cycle read sees old value
    step("R7", 1, 1, 5'd3, 64'h1234_5678_9abc_def0, 0, 5'd6, 1, 5'd3);
    step("R7", 1, 0, 5'd7, 64'h0_0bad_f00d, 0, 5'd7, 1, 5'd3);
    step("R6", 0, 0, 0, 0, 1, 5'd3, 0, 5'd7);
    // R8: illegal double write dropped
    step("R11", 1, 0, 5'd20, 64'h0_7777_8888, 0, 5'd20, 0, 5'd0);
    step("R8", 1, 1, 5'd20, 64'hffff_ffff_ffff_ffff, 0, 5'd20, 1, 5'd10);
    step("R8", 1, 1, 5'd31, 64'hffff_ffff_ffff_ffff, 0, 5'd20, 1, 5'd2);
    step("R8", 0, 0, 0, 0, 0, 5'd20, 0, 5'd31);
    for (int i = 0; i < 32; i++) step("R8 sweep", 0, 0, 0, 0, 0, 5'(i), 1, 5'(i % 16));
    // R9: out-of-range double read
    step("R9", 0, 1, 5'd20, 0, 1, 5'd16, 1, 5'd31);
    // R10: random traffic on both ports
    for (int i = 0; i < 2000; i++)
      step("R10", 1'($urandom), 1'($urandom), 5'($urandom), {$urandom, $urandom},
           1'($urandom), 5'($urandom), 1'($urandom), 5'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule